// File: doc/BRIEF.md
# Two-Stage Cascaded Clock Divider

The block divides a fast clock by the product of two programmable stages. Each stage holds a 4-bit high-count field and a 4-bit low-count field. Each field holds the number of cycles minus one. A stage's ratio is therefore (high+1)+(low+1), which runs from 2 to 32. Either stage can be bypassed. With both stages active, the second stage counts whole periods of the first, so the overall ratio is the product of the two stage ratios, up to 1024. Ratios that are not such a product cannot be produced.

Everything runs in the fast clock domain. The second stage advances only on a clock enable that the first stage raises once per period, so there is no derived clock inside the block. A synchronous sync input restarts both stages together. The output phase after sync is therefore fixed: the output goes high on the edge that samples sync. Using only the second stage, with the first bypassed, is not supported. The block flags that case and passes the input clock through.

Top module: `casc_div`

## Requirements
- R1: A stage with high field H and low field L (4 bits each, value = cycles − 1) has a period of H+L+2 input cycles. After a restart it is high for the first H+1 cycles and low for the next L+1 cycles.
- R2: With both bypass bits set (s1_byp_i=1, s2_byp_i=1), clk_o equals clk_i: high while clk_i is high and low while it is low.
- R3: With only the second stage bypassed (s1_byp_i=0, s2_byp_i=1), clk_o is the first stage's level and has a period of H1+L1+2.
- R4: With neither stage bypassed, clk_o is high for (H2+1)·D1 cycles and low for (L2+1)·D1 cycles, where D1=H1+L1+2. The period is D1·(H2+L2+2), which is 1024 when all four fields are 15.
- R5: sync_i sampled high on a rising edge restarts both stages at once. clk_o is high in the cycle that follows, and counting restarts from that edge.
- R6: config_error_o is 1 exactly when s1_byp_i=1 and s2_byp_i=0. In that case clk_o passes clk_i through, as in R2.
- R7: While rst_ni is low, both stages are held at their start state, so clk_o is high in the divided modes. The internal reset is released synchronously, two rising edges after rst_ni goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Synchronous restart of both stages |
| s1_hi_i | input | 4 | Stage 1 high cycles minus one |
| s1_lo_i | input | 4 | Stage 1 low cycles minus one |
| s2_hi_i | input | 4 | Stage 2 high periods minus one |
| s2_lo_i | input | 4 | Stage 2 low periods minus one |
| s1_byp_i | input | 1 | Bypass stage 1 |
| s2_byp_i | input | 1 | Bypass stage 2 |
| clk_o | output | 1 | Divided clock |
| config_error_o | output | 1 | Unsupported bypass combination |

## Verification
The bench builds the block with its default parameters: 4-bit fields and a two-flop reset synchronizer. With these values the smallest ratio of 2 and the largest ratio of 1024 can both be reached in runs of a few thousand cycles. Each bypass combination is run with directed extreme field values and with random ones. The output is sampled in both halves of every input cycle, so the pass-through modes are told apart from a constant high output. A restart in mid-period checks that the phase realigns at once.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_ONE  = 2'd1,
    MODE_TWO  = 2'd2,
    MODE_BAD  = 2'd3
  } cdiv_mode_e;

  localparam int unsigned NUM_STAGES = 2;
endpackage

// File: rtl/cdiv_rst_sync.sv
module cdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/cdiv_stage.sv
module cdiv_stage #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             lvl_o,
  output logic [CNT_W:0]   cnt_o,
  output logic             wrap_o
);
  localparam int unsigned SC_W = CNT_W + 1;

  logic [SC_W-1:0] last_w;
  logic [SC_W-1:0] cnt_q, cnt_d;
  logic            lvl_q, lvl_d;

  // final count of the period; >= keeps the counter live after a field shrinks
  assign last_w = {1'b0, hi_i} + {1'b0, lo_i} + SC_W'(1);
  assign wrap_o = en_i && (cnt_q >= last_w);

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (clr_i) begin
      cnt_d = '0;
      lvl_d = 1'b1;
    end else if (en_i) begin
      cnt_d = wrap_o ? '0 : cnt_q + SC_W'(1);
      lvl_d = (cnt_d <= {1'b0, hi_i});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/cdiv_mode_dec.sv
module cdiv_mode_dec
  import cdiv_pkg::*;
(
  input  logic                  byp1_i,
  input  logic                  byp2_i,
  output cdiv_mode_e            mode_o,
  output logic [NUM_STAGES-1:0] use_o,
  output logic                  err_o
);
  always_comb begin
    unique case ({byp1_i, byp2_i})
      2'b11:   mode_o = MODE_PASS;
      2'b01:   mode_o = MODE_ONE;
      2'b00:   mode_o = MODE_TWO;
      default: mode_o = MODE_BAD;
    endcase
  end

  // a stage counts only when its result can reach the output
  assign use_o[0] = (mode_o == MODE_ONE) || (mode_o == MODE_TWO);
  assign use_o[1] = (mode_o == MODE_TWO);
  assign err_o    = (mode_o == MODE_BAD);
endmodule

// File: rtl/cdiv_out_sel.sv
module cdiv_out_sel
  import cdiv_pkg::*;
(
  input  logic                  clk_i,
  input  cdiv_mode_e            mode_i,
  input  logic [NUM_STAGES-1:0] lvl_i,
  output logic                  clk_o
);
  always_comb begin
    unique case (mode_i)
      MODE_ONE: clk_o = lvl_i[0];
      MODE_TWO: clk_o = lvl_i[1];
      default:  clk_o = clk_i;
    endcase
  end
endmodule

// File: rtl/casc_div.sv
module casc_div
  import cdiv_pkg::*;
#(
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] s1_hi_i,
  input  logic [CNT_W-1:0] s1_lo_i,
  input  logic [CNT_W-1:0] s2_hi_i,
  input  logic [CNT_W-1:0] s2_lo_i,
  input  logic             s1_byp_i,
  input  logic             s2_byp_i,
  output logic             clk_o,
  output logic             config_error_o
);
  localparam int unsigned SC_W = CNT_W + 1;

  logic                  rst_int;
  cdiv_mode_e            mode;
  logic [NUM_STAGES-1:0] use_stage;
  logic [NUM_STAGES-1:0] en;
  logic [NUM_STAGES-1:0] wrap;
  logic [NUM_STAGES-1:0] lvl;
  logic [CNT_W-1:0]      hi_f  [NUM_STAGES];
  logic [CNT_W-1:0]      lo_f  [NUM_STAGES];
  logic [SC_W-1:0]       cnt_f [NUM_STAGES];
  logic [SC_W-1:0]       cnt1, cnt2;
  logic                  wrap1;
  logic                  unused_wrap;

  assign hi_f[0] = s1_hi_i;
  assign lo_f[0] = s1_lo_i;
  assign hi_f[1] = s2_hi_i;
  assign lo_f[1] = s2_lo_i;

  cdiv_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int)
  );

  cdiv_mode_dec u_dec (
    .byp1_i (s1_byp_i),
    .byp2_i (s2_byp_i),
    .mode_o (mode),
    .use_o  (use_stage),
    .err_o  (config_error_o)
  );

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign en[g] = use_stage[g];
    end else begin : g_chain
      // later stage steps once per period of the stage before it
      assign en[g] = use_stage[g] & wrap[g-1];
    end

    cdiv_stage #(.CNT_W(CNT_W)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_int),
      .en_i   (en[g]),
      .clr_i  (sync_i),
      .hi_i   (hi_f[g]),
      .lo_i   (lo_f[g]),
      .lvl_o  (lvl[g]),
      .cnt_o  (cnt_f[g]),
      .wrap_o (wrap[g])
    );
  end

  cdiv_out_sel u_sel (
    .clk_i  (clk_i),
    .mode_i (mode),
    .lvl_i  (lvl),
    .clk_o  (clk_o)
  );

  assign cnt1        = cnt_f[0];
  assign cnt2        = cnt_f[1];
  assign wrap1       = wrap[0];
  assign unused_wrap = wrap[NUM_STAGES-1];
endmodule

// File: rtl/casc_div_chk.sv
module casc_div_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_int,
  input logic             sync_i,
  input logic [CNT_W-1:0] s1_hi_i,
  input logic [CNT_W-1:0] s1_lo_i,
  input logic             s1_byp_i,
  input logic             s2_byp_i,
  input logic             config_error_o,
  input logic [CNT_W:0]   cnt1,
  input logic [CNT_W:0]   cnt2,
  input logic             wrap1
);
  logic [CNT_W:0] lim1;
  assign lim1 = {1'b0, s1_hi_i} + {1'b0, s1_lo_i} + (CNT_W+1)'(1);

  AST_SYNC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_int)
    sync_i |=> (cnt1 == '0) && (cnt2 == '0)); // R5

  AST_S1_STEP: assert property (@(posedge clk_i) disable iff (!rst_int)
    (!sync_i && !s1_byp_i && (cnt1 < lim1)) |=> (cnt1 == $past(cnt1) + 1'b1)); // R1

  AST_S2_HOLD: assert property (@(posedge clk_i) disable iff (!rst_int)
    (!sync_i && !wrap1) |=> $stable(cnt2)); // R4

  AST_ERR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_int)
    (s1_byp_i && !s2_byp_i) |-> config_error_o); // R6

  AST_RST_HOLD: assert property (@(posedge clk_i)
    !rst_int |-> (cnt1 == '0) && (cnt2 == '0)); // R7
endmodule

bind casc_div casc_div_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_int        (rst_int),
  .sync_i         (sync_i),
  .s1_hi_i        (s1_hi_i),
  .s1_lo_i        (s1_lo_i),
  .s1_byp_i       (s1_byp_i),
  .s2_byp_i       (s2_byp_i),
  .config_error_o (config_error_o),
  .cnt1           (cnt1),
  .cnt2           (cnt2),
  .wrap1          (wrap1)
);

// File: tb/sim_casc_div.sv
`timescale 1ns/1ps
module sim_casc_div;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       sync_i;
  logic [3:0] h1, l1, h2, l2;
  logic       b1, b2;
  logic       clk_o, err_o;

  int checks = 0;
  int errors = 0;
  int t      = 0;
  bit valid  = 1'b0;

  always #10 clk = ~clk;

  casc_div u0 (
    .clk_i (clk), .rst_ni (rst_ni), .sync_i (sync_i),
    .s1_hi_i (h1), .s1_lo_i (l1), .s2_hi_i (h2), .s2_lo_i (l2),
    .s1_byp_i (b1), .s2_byp_i (b2),
    .clk_o (clk_o), .config_error_o (err_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0d cfg=%0b%0b %0d/%0d %0d/%0d",
               req, act, exp, t, b1, b2, h1, l1, h2, l2);
    end
  endtask

  function automatic logic model_out(input bit hi_phase);
    int d1, d2;
    d1 = int'(h1) + int'(l1) + 2;
    d2 = int'(h2) + int'(l2) + 2;
    if (b1) return hi_phase;                          // R2 / R6 pass-through
    if (b2) return ((t % d1) < int'(h1) + 1);         // R1 R3
    return (((t / d1) % d2) < int'(h2) + 1);          // R4
  endfunction

  function automatic string tag();
    if (b1 && b2)  return "R2";
    if (b1)        return "R6";
    if (b2)        return "R1 R3";
    return "R4";
  endfunction

  // reference phase counter, restarted by sync
  always @(posedge clk) begin
    if (!rst_ni)      valid = 1'b0;
    else if (sync_i)  begin valid = 1'b1; t = 0; end
    else if (valid)   t++;
  end

  always @(posedge clk) begin
    #5;
    if (valid) begin
      chk(tag(), clk_o, model_out(1'b1));
      chk("R6 flag", err_o, b1 & ~b2);
    end
  end

  always @(negedge clk) begin
    #5;
    if (valid) chk(tag(), clk_o, model_out(1'b0));
  end

  task automatic run_cfg(input logic p1, input logic p2, input logic [3:0] a, input logic [3:0] b,
                         input logic [3:0] c, input logic [3:0] d, input int n);
    @(negedge clk);
    valid = 1'b0;
    b1 = p1; b2 = p2; h1 = a; l1 = b; h2 = c; l2 = d;
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic mid_sync();
    @(negedge clk);
    sync_i = 1'b1;
    @(posedge clk);
    #5 chk("R5 restart high", clk_o, 1'b1);
    @(negedge clk);
    sync_i = 1'b0;
  endtask

  initial begin
    rst_ni = 1'b0; sync_i = 1'b0;
    b1 = 1'b0; b2 = 1'b1; h1 = 4'd2; l1 = 4'd3; h2 = 4'd0; l2 = 4'd0;
    #35;
    chk("R7 reset level", clk_o, 1'b1);
    chk("R7 reset flag", err_o, 1'b0);
    b1 = 1'b1; b2 = 1'b0;
    #1 chk("R6 flag in reset", err_o, 1'b1);
    b1 = 1'b0; b2 = 1'b1;
    @(negedge clk); rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    run_cfg(1'b0, 1'b1, 4'd0,  4'd0,  4'd0, 4'd0, 40);    // R1 ratio 2
    run_cfg(1'b0, 1'b1, 4'd15, 4'd15, 4'd0, 4'd0, 80);    // R1 ratio 32
    run_cfg(1'b0, 1'b1, 4'd4,  4'd9,  4'd0, 4'd0, 50);    // R3
    run_cfg(1'b1, 1'b1, 4'd7,  4'd2,  4'd3, 4'd1, 20);    // R2
    run_cfg(1'b1, 1'b0, 4'd7,  4'd2,  4'd3, 4'd1, 20);    // R6
    run_cfg(1'b0, 1'b0, 4'd0,  4'd0,  4'd0, 4'd0, 20);    // R4 ratio 4
    run_cfg(1'b0, 1'b0, 4'd2,  4'd1,  4'd3, 4'd4, 80);    // R4 ratio 45
    run_cfg(1'b0, 1'b0, 4'd15, 4'd15, 4'd15, 4'd15, 2100); // R4 ratio 1024
    run_cfg(1'b0, 1'b0, 4'd3,  4'd5,  4'd1, 4'd2, 37);
    mid_sync();                                            // R5
    repeat (90) @(negedge clk);
    run_cfg(1'b0, 1'b1, 4'd6,  4'd1,  4'd0, 4'd0, 5);
    mid_sync();                                            // R5
    repeat (30) @(negedge clk);

    for (int i = 0; i < 40; i++) begin
      logic [3:0] ra, rb, rc, rd;
      logic       p1, p2;
      int         n;
      p1 = 1'($urandom_range(1, 0)); p2 = 1'($urandom_range(1, 0));
      ra = 4'($urandom_range(15, 0)); rb = 4'($urandom_range(15, 0));
      rc = 4'($urandom_range(15, 0)); rd = 4'($urandom_range(15, 0));
      n = (int'(ra) + int'(rb) + 2) * (int'(rc) + int'(rd) + 2) * 2 + 5;
      if (n > 2100) n = 2100;
      run_cfg(p1, p2, ra, rb, rc, rd, n);
    end

    @(negedge clk); valid = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule